// File: doc/BRIEF.md
# Dual-Port Mailbox Memory

This block is a synchronous two-port word store shared by two processors, called the left side and the right side. Each side has its own enable, direction, output-enable, address and data pins, so both can read or write any word in the same clock cycle. Read data is registered, so a read returns the stored word one clock after it is requested.

The two highest addresses double as doorbells. When one side writes the word reserved for its partner, the partner's active-low interrupt output goes low. The partner acknowledges by making a read-enabled access to that word. The doorbell words still hold ordinary data, so the writer can leave a message there for the interrupted side to fetch. Each side also has a write-block input. While it is high, that side's writes change no storage and ring no doorbell. A system arbiter can drive it when both sides contend for one address.

The pins are plain control and data pins with no valid/ready pair. Every enabled access completes in one cycle, and the block never applies back-pressure.

Top module: `dpmb_mailbox`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, both interrupt outputs are high after that edge and both read-data outputs are zero. Word contents after reset are undefined.
- R2: When a side's `ce_n` is low and its `we_n` is high, its `rd` output holds the word at its address one clock later. The value is the one stored before any write made in that same cycle. In any other cycle, `rd` keeps its value.
- R3: A side stores `wd` at its address only when its `ce_n` and `we_n` are both low and its `blk` is low. A write attempt with `ce_n` high leaves the word unchanged.
- R4: A stored write from the right side to address DEPTH-2 (0x7FE) drives `irq_n_l` low at the next edge. A left-side write to that address does not.
- R5: A stored write from the left side to address DEPTH-1 (0x7FF) drives `irq_n_r` low at the next edge. A right-side write to that address does not.
- R6: The left interrupt is released, with `irq_n_l` high after the edge, when the left side accesses 0x7FE with `ce_n_l` and `oe_n_l` both low. The level of `we_n_l` does not matter.
- R7: The right interrupt is released in the same way when the right side accesses 0x7FF with `ce_n_r` and `oe_n_r` both low, whatever the level of `we_n_r`.
- R8: The words at 0x7FE and 0x7FF store and return data like any other address.
- R9: While a side's `blk` is high, its write changes no word and sets no interrupt.
- R10: If a flag is set and released in the same cycle, it ends up set.
- R11: If both sides store to the same address in one cycle, the left side's data is kept.
- R12: An access to a doorbell word with `oe_n` high does not release the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n_l | input | 1 | Left enable, active low |
| we_n_l | input | 1 | Left direction: low writes, high reads |
| oe_n_l | input | 1 | Left output enable, active low (qualifies the doorbell release) |
| blk_l | input | 1 | Left write block, active high |
| addr_l | input | ADDR_W | Left word address |
| wd_l | input | DATA_W | Left write data |
| rd_l | output | DATA_W | Left registered read data |
| irq_n_l | output | 1 | Left interrupt, active low |
| ce_n_r | input | 1 | Right enable, active low |
| we_n_r | input | 1 | Right direction: low writes, high reads |
| oe_n_r | input | 1 | Right output enable, active low |
| blk_r | input | 1 | Right write block, active high |
| addr_r | input | ADDR_W | Right word address |
| wd_r | input | DATA_W | Right write data |
| rd_r | output | DATA_W | Right registered read data |
| irq_n_r | output | 1 | Right interrupt, active low |

## Verification
The random traffic confines both addresses to a handful of low words plus the two doorbells. This makes same-address collisions, doorbell writes and acknowledges frequent. It tells apart left-over-right write priority, read-before-write data, and doorbell decoding by side. Each control pin is randomized on its own, so the stimulus also covers writes blocked by `blk` or `ce_n`, and acknowledges with `oe_n` high or with `we_n` at either level. Directed cases force the exact corners: set and release of one flag in the same cycle, a blocked doorbell write, an identical-address double write, and a release attempt with `oe_n` high.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  // Doorbell owned by a side: the word whose write interrupts that side.
  function automatic int unsigned bell_addr(side_e s, int unsigned depth);
    return (s == SIDE_L) ? depth - 2 : depth - 1;
  endfunction
endpackage

// File: rtl/dpmb_array.sv
module dpmb_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen_a,
  input  logic              ren_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wd_a,
  output logic [DATA_W-1:0] rd_a,
  input  logic              wen_b,
  input  logic              ren_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wd_b,
  output logic [DATA_W-1:0] rd_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Port b stored first so port a (left) wins a same-address collision.
  always_ff @(posedge clk) begin
    if (wen_b) mem[addr_b] <= wd_b;
    if (wen_a) mem[addr_a] <= wd_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a <= '0;
      rd_b <= '0;
    end else begin
      if (ren_a) rd_a <= mem[addr_a];
      if (ren_b) rd_b <= mem[addr_b];
    end
  end

  // R1
  rd_reset_chk: assert property (@(posedge clk) rst |=> (rd_a == '0 && rd_b == '0));
  // R2
  rd_hold_a_chk: assert property (@(posedge clk) disable iff (rst) !ren_a |=> $stable(rd_a));
  // R2
  rd_hold_b_chk: assert property (@(posedge clk) disable iff (rst) !ren_b |=> $stable(rd_b));
endmodule

// File: rtl/dpmb_flag.sv
module dpmb_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst) set |=> flag);
  // R6
  clr_drop_chk: assert property (@(posedge clk) disable iff (rst) (clr && !set) |=> !flag);
  // R12
  idle_keep_chk: assert property (@(posedge clk) disable iff (rst) (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/dpmb_mailbox.sv
module dpmb_mailbox #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n_l,
  input  logic              we_n_l,
  input  logic              oe_n_l,
  input  logic              blk_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] wd_l,
  output logic [DATA_W-1:0] rd_l,
  output logic              irq_n_l,
  input  logic              ce_n_r,
  input  logic              we_n_r,
  input  logic              oe_n_r,
  input  logic              blk_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wd_r,
  output logic [DATA_W-1:0] rd_r,
  output logic              irq_n_r
);
  import dpmb_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BELL_L = ADDR_W'(bell_addr(SIDE_L, DEPTH));
  localparam logic [ADDR_W-1:0] BELL_R = ADDR_W'(bell_addr(SIDE_R, DEPTH));

  logic [1:0]              ce_n, we_n, oe_n, blk, wen, ren, set, clr, flag;
  logic [1:0][ADDR_W-1:0]  addr;
  logic [1:0][ADDR_W-1:0]  bell;

  assign ce_n = {ce_n_r, ce_n_l};
  assign we_n = {we_n_r, we_n_l};
  assign oe_n = {oe_n_r, oe_n_l};
  assign blk  = {blk_r, blk_l};
  assign addr = {addr_r, addr_l};
  assign bell = {BELL_R, BELL_L};

  for (genvar s = 0; s < 2; s++) begin : g_side
    assign wen[s] = !ce_n[s] && !we_n[s] && !blk[s];
    assign ren[s] = !ce_n[s] && we_n[s];
    // Partner's stored write to this side's doorbell rings it.
    assign set[s] = wen[1-s] && (addr[1-s] == bell[s]);
    assign clr[s] = !ce_n[s] && !oe_n[s] && (addr[s] == bell[s]);

    dpmb_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set  (set[s]),
      .clr  (clr[s]),
      .flag (flag[s])
    );
  end

  assign irq_n_l = !flag[0];
  assign irq_n_r = !flag[1];

  dpmb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk    (clk),
    .rst    (rst),
    .wen_a  (wen[0]),
    .ren_a  (ren[0]),
    .addr_a (addr_l),
    .wd_a   (wd_l),
    .rd_a   (rd_l),
    .wen_b  (wen[1]),
    .ren_b  (ren[1]),
    .addr_b (addr_r),
    .wd_b   (wd_r),
    .rd_b   (rd_r)
  );

  // R1
  irq_reset_chk: assert property (@(posedge clk) rst |=> (irq_n_l && irq_n_r));
  // R9
  blk_no_ring_l_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_n_l && (ce_n_r || we_n_r || blk_r || addr_r != BELL_L)) |=> irq_n_l);
  // R9
  blk_no_ring_r_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_n_r && (ce_n_l || we_n_l || blk_l || addr_l != BELL_R)) |=> irq_n_r);
  // R4
  ring_l_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n_r && !we_n_r && !blk_r && addr_r == BELL_L) |=> !irq_n_l);
endmodule

// File: tb/dpmb_mailbox_bench.sv
module dpmb_mailbox_bench;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] BL = AW'(DEPTH - 2);
  localparam logic [AW-1:0] BR = AW'(DEPTH - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n_l = 1, we_n_l = 1, oe_n_l = 1, blk_l = 0;
  logic ce_n_r = 1, we_n_r = 1, oe_n_r = 1, blk_r = 0;
  logic [AW-1:0] addr_l = '0, addr_r = '0;
  logic [DW-1:0] wd_l = '0, wd_r = '0;
  logic [DW-1:0] rd_l, rd_r;
  logic irq_n_l, irq_n_r;

  always #4 clk = ~clk;

  dpmb_mailbox u_dpmb_mailbox (
    .clk(clk), .rst(rst),
    .ce_n_l(ce_n_l), .we_n_l(we_n_l), .oe_n_l(oe_n_l), .blk_l(blk_l),
    .addr_l(addr_l), .wd_l(wd_l), .rd_l(rd_l), .irq_n_l(irq_n_l),
    .ce_n_r(ce_n_r), .we_n_r(we_n_r), .oe_n_r(oe_n_r), .blk_r(blk_r),
    .addr_r(addr_r), .wd_r(wd_r), .rd_r(rd_r), .irq_n_r(irq_n_r)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [DEPTH];
  bit            m_ok  [DEPTH];
  logic [DW-1:0] e_rd_l, e_rd_r;
  bit            k_rd_l, k_rd_r;
  bit            f_l, f_r;

  function automatic bit wr_l();
    return !ce_n_l && !we_n_l && !blk_l;
  endfunction
  function automatic bit wr_r();
    return !ce_n_r && !we_n_r && !blk_r;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply current inputs for one clock, update the model, compare after the edge.
  task automatic tick(string tag);
    bit sl, cl, sr, cr;
    if (rst) begin
      e_rd_l = '0; e_rd_r = '0; k_rd_l = 1; k_rd_r = 1; f_l = 0; f_r = 0;
    end else begin
      if (!ce_n_l && we_n_l) begin e_rd_l = m_mem[addr_l]; k_rd_l = m_ok[addr_l]; end
      if (!ce_n_r && we_n_r) begin e_rd_r = m_mem[addr_r]; k_rd_r = m_ok[addr_r]; end
      sl = wr_r() && addr_r == BL;
      cl = !ce_n_l && !oe_n_l && addr_l == BL;
      sr = wr_l() && addr_l == BR;
      cr = !ce_n_r && !oe_n_r && addr_r == BR;
      f_l = sl ? 1'b1 : (cl ? 1'b0 : f_l);
      f_r = sr ? 1'b1 : (cr ? 1'b0 : f_r);
    end
    if (wr_r()) begin m_mem[addr_r] = wd_r; m_ok[addr_r] = 1; end
    if (wr_l()) begin m_mem[addr_l] = wd_l; m_ok[addr_l] = 1; end
    @(negedge clk);
    if (k_rd_l) chk({tag, " rd_l"}, rd_l, e_rd_l);
    if (k_rd_r) chk({tag, " rd_r"}, rd_r, e_rd_r);
    chk({tag, " irq_n_l"}, DW'(irq_n_l), DW'(!f_l));
    chk({tag, " irq_n_r"}, DW'(irq_n_r), DW'(!f_r));
  endtask

  task automatic idle();
    ce_n_l = 1; we_n_l = 1; oe_n_l = 1; blk_l = 0;
    ce_n_r = 1; we_n_r = 1; oe_n_r = 1; blk_r = 0;
  endtask
  task automatic pw_l(logic [AW-1:0] a, logic [DW-1:0] d);
    ce_n_l = 0; we_n_l = 0; oe_n_l = 1; addr_l = a; wd_l = d;
  endtask
  task automatic pw_r(logic [AW-1:0] a, logic [DW-1:0] d);
    ce_n_r = 0; we_n_r = 0; oe_n_r = 1; addr_r = a; wd_r = d;
  endtask
  task automatic pr_l(logic [AW-1:0] a, logic oe);
    ce_n_l = 0; we_n_l = 1; oe_n_l = oe; addr_l = a;
  endtask
  task automatic pr_r(logic [AW-1:0] a, logic oe);
    ce_n_r = 0; we_n_r = 1; oe_n_r = oe; addr_r = a;
  endtask

  function automatic logic [AW-1:0] pick_addr(int unsigned r);
    case (r % 4)
      0: return BL;
      1: return BR;
      default: return AW'(r % 6);
    endcase
  endfunction

  initial begin
    int unsigned seed;
    seed = 32'h1F2E3D4C;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) m_ok[i] = 0;
    @(negedge clk);
    tick("R1 reset");
    tick("R1 reset");
    rst = 0;

    // R3: write, then a write attempt with ce_n high, then read
    idle(); pw_l(5, 8'h11); tick("R3 store");
    idle(); pw_l(5, 8'hAA); ce_n_l = 1; tick("R3 ce_n high write");
    idle(); pr_l(5, 1); tick("R3 readback");
    idle(); tick("R2 rd");

    // R8 / R4: right writes left doorbell with message
    idle(); pw_r(BL, 8'h5A); tick("R4 ring left");
    idle(); pr_l(BL, 1); tick("R12 oe high no release");
    idle(); pr_l(BL, 1); tick("R8 msg");
    idle(); pr_l(BL, 0); we_n_l = 0; blk_l = 1; tick("R6 release we low");
    idle(); tick("R8 msg read");

    // R5 / R7
    idle(); pw_l(BR, 8'hC3); tick("R5 ring right");
    idle(); pw_r(BR, 8'h77); tick("R5 own write no ring");
    idle(); pr_r(BR, 0); tick("R7 release");
    idle(); tick("R7 rd");

    // R10: set and release of left flag same cycle
    idle(); pw_r(BL, 8'h01); pr_l(BL, 0); tick("R10 set wins");
    idle(); tick("R10 hold");

    // R9: blocked doorbell write
    idle(); pr_l(BL, 0); tick("R9 clear first");
    idle(); pw_r(BL, 8'hEE); blk_r = 1; tick("R9 blocked ring");
    idle(); pr_l(BL, 1); tick("R9 word unchanged");
    idle(); tick("R9 rd");

    // R11: both write same address
    idle(); pw_l(2, 8'h3C); pw_r(2, 8'hC3); tick("R11 collide");
    idle(); pr_r(2, 1); tick("R11 left kept");
    idle(); tick("R11 rd");

    // R2 read-before-write across sides
    idle(); pw_l(4, 8'h44); tick("R2 seed");
    idle(); pw_l(4, 8'h55); pr_r(4, 1); tick("R2 old data");
    idle(); tick("R2 rd");

    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom();
      ce_n_l = (r[1:0] == 0); we_n_l = r[2]; oe_n_l = r[3]; blk_l = (r[6:4] == 0);
      ce_n_r = (r[8:7] == 0); we_n_r = r[9]; oe_n_r = r[10]; blk_r = (r[13:11] == 0);
      addr_l = pick_addr($urandom()); addr_r = pick_addr($urandom());
      wd_l = DW'($urandom()); wd_r = DW'($urandom());
      tick("R2 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule